// File: doc/BRIEF.md
# CAN Operating-Mode and Bus-Off Recovery Controller

This block holds the operating-mode register of a CAN node and decides when the node may take part in bus traffic. The register has five live bits: a reset-mode bit, a listen-only bit, a self-test bit, a filter-width select and a sleep request. The block keeps the node off the bus while reset mode is active. When software clears reset mode, the block watches the sampled bus level at every bit-time tick and enables the node again only after the bus has been seen idle for long enough.

A hardware reset, a software request or a bus-off event can each put the node into reset mode. The block remembers which one did. After a hardware or software reset, one idle sequence of eleven recessive bits is enough to rejoin the bus. After bus-off, the node must see 128 such sequences. On bus-off the block also raises the controls that reinitialize the error counters. The three configuration bits can only be changed while reset mode is already in force. A software change of the reset-mode bit takes effect on an internal half-rate clock phase.

The surrounding controller uses `bus_on` as the gate for its bit-stream engine. It uses `xfer_abort` to drop any frame in progress, and it uses the two error-counter controls to reload those counters.

Top module: `can_mode_ctrl`

## Requirements
- R1: While `ext_rst` is high, and in the first cycle after it falls, `mode_rd` reads 0x01 and `bus_on` is 0. A write made while `ext_rst` is high has no effect, so the reset-mode bit still reads 1 after release.
- R2: Bits 7 to 5 of `mode_rd` always read 0.
- R3: Register layout: bit 3 is the filter-width select, bit 2 is self-test and bit 1 is listen-only. A write updates these three bits in the cycle after the write edge only if bit 0 of `mode_rd` was 1 at that write. Otherwise the write leaves them unchanged.
- R4: A software write changes bit 0 (reset mode) of `mode_rd` one or two cycles after the write edge, on the next active phase of a clock running at half the input rate. In the cycle right after the write edge, bit 0 still shows its old value.
- R5: A rising edge on `bus_off` sets bit 0 of `mode_rd` in the next cycle. In that same cycle `rxerr_clr` and `txerr_load` are both 1 for exactly one cycle, and `txerr_load_val` is 127.
- R6: `xfer_abort` is 1 for exactly one cycle each time bit 0 of `mode_rd` goes from 0 to 1, whether a software write or bus-off caused it.
- R7: A bus-free sequence is 11 consecutive `bit_tick` samples with `bus_rx` = 1 (recessive). A tick with `bus_rx` = 0 restarts the count from zero.
- R8: If the last entry into reset mode came from a hardware or software reset, `bus_on` rises in the cycle after the tick that completes the first bus-free sequence seen after bit 0 clears.
- R9: If the last entry into reset mode came from bus-off, `bus_on` stays 0 after 127 bus-free sequences and rises after the 128th.
- R10: Recessive ticks seen while bit 0 is 1 do not count toward recovery.
- R11: `bus_on` is 0 in every cycle in which bit 0 of `mode_rd` is 1.
- R12: Bit 4 (sleep) takes the written value only while bit 0 reads 0 at the write. It reads 0 whenever bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst | input | 1 | Hardware reset, active high, synchronous |
| cpu_wr | input | 1 | Mode register write strobe |
| cpu_wdata | input | 5 | Write data for mode bits 4..0 |
| mode_rd | output | 8 | Mode register read value |
| bus_off | input | 1 | Bus-off status from the error logic |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| bus_on | output | 1 | Node may take part in bus traffic |
| xfer_abort | output | 1 | Pulse: drop any frame in progress |
| rxerr_clr | output | 1 | Pulse: clear the receive error counter |
| txerr_load | output | 1 | Pulse: load the transmit error counter |
| txerr_load_val | output | 8 | Value for the transmit error counter load |

## Verification
Suppose the stored cause of the last reset is wrong. Then `bus_on` rises 127 sequences too early or too late, which is visible in the cycle after the deciding tick. A recessive-bit counter that fails to clear on a dominant bit, or that keeps counting during reset mode, makes `bus_on` rise one or more ticks early. A fault in the write protection or the half-rate phase shows up at `mode_rd` within two cycles of a write. Bus-off handling is checked in the cycle right after the rising edge, through the abort and error-counter pulses.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int MODE_W  = 8;
    localparam int FIELD_W = 5;
    localparam int RSV_W   = MODE_W - FIELD_W;

    localparam int RM_BIT    = 0;
    localparam int LISTEN_BIT = 1;
    localparam int SELFT_BIT = 2;
    localparam int FILT_BIT  = 3;
    localparam int SLEEP_BIT = 4;

    typedef enum logic [1:0] {
        CAUSE_HW     = 2'd0,
        CAUSE_CPU    = 2'd1,
        CAUSE_BUSOFF = 2'd2
    } rst_cause_e;

    typedef struct packed {
        logic sleep;
        logic filt_single;
        logic self_test;
        logic listen_only;
        logic rst_mode;
    } mode_bits_t;

    typedef struct packed {
        mode_bits_t mode;
        logic       rm_req;
        rst_cause_e cause;
        logic       bus_off_prev;
        logic       abort;
        logic       err_init;
        logic       online;
    } ctl_t;

endpackage

// File: rtl/cmc_half_phase.sv
module cmc_half_phase (
    input  logic clk,
    input  logic ext_rst,
    output logic phase_hi
);
    logic ph_d, ph_q;

    always_comb begin
        ph_d = ~ph_q;
    end

    always_ff @(posedge clk) begin
        if (ext_rst) ph_q <= 1'b0;
        else         ph_q <= ph_d;
    end

    assign phase_hi = ph_q;
endmodule

// File: rtl/cmc_free_detect.sv
module cmc_free_detect #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic ext_rst,
    input  logic en,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic seq_pulse
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        run_d     = run_q;
        seq_pulse = 1'b0;
        if (!en) begin
            run_d = '0;
        end else if (bit_tick) begin
            if (!bus_rx) begin
                run_d = '0;
            end else if (run_q == LAST) begin
                run_d     = '0;
                seq_pulse = 1'b1;
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ext_rst) run_q <= '0;
        else         run_q <= run_d;
    end
endmodule

// File: rtl/cmc_seq_counter.sv
module cmc_seq_counter #(
    parameter int MAX_SEQ = 128,
    localparam int SW     = $clog2(MAX_SEQ + 1)
) (
    input  logic          clk,
    input  logic          ext_rst,
    input  logic          en,
    input  logic          seq_pulse,
    input  logic [SW-1:0] target,
    output logic          done
);
    logic [SW-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        done   = 1'b0;
        if (!en) begin
            seen_d = '0;
        end else if (seq_pulse) begin
            seen_d = seen_q + 1'b1;
            done   = (seen_q == target - SW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (ext_rst) seen_q <= '0;
        else         seen_q <= seen_d;
    end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int RUN_LEN     = 11,
    parameter int NORMAL_SEQS = 1,
    parameter int BUSOFF_SEQS = 128,
    parameter int ERR_W       = 8,
    parameter int TEC_INIT    = 127
) (
    input  logic               clk,
    input  logic               ext_rst,
    input  logic               cpu_wr,
    input  logic [FIELD_W-1:0] cpu_wdata,
    output logic [MODE_W-1:0]  mode_rd,
    input  logic               bus_off,
    input  logic               bit_tick,
    input  logic               bus_rx,
    output logic               bus_on,
    output logic               xfer_abort,
    output logic               rxerr_clr,
    output logic               txerr_load,
    output logic [ERR_W-1:0]   txerr_load_val
);
    localparam int MAX_SEQ = (BUSOFF_SEQS > NORMAL_SEQS) ? BUSOFF_SEQS : NORMAL_SEQS;
    localparam int SW      = $clog2(MAX_SEQ + 1);

    localparam ctl_t CTL_RST = '{
        mode:         '{sleep: 1'b0, filt_single: 1'b0, self_test: 1'b0,
                        listen_only: 1'b0, rst_mode: 1'b1},
        rm_req:       1'b1,
        cause:        CAUSE_HW,
        bus_off_prev: 1'b0,
        abort:        1'b0,
        err_init:     1'b0,
        online:       1'b0
    };

    ctl_t q, d;

    logic          phase_hi;
    logic          count_en;
    logic          seq_pulse;
    logic          seq_done;
    logic          busoff_ev;
    logic [SW-1:0] seq_target;

    cmc_half_phase u_phase (
        .clk      (clk),
        .ext_rst  (ext_rst),
        .phase_hi (phase_hi)
    );

    assign count_en   = ~q.mode.rst_mode & ~q.online;
    assign seq_target = (q.cause == CAUSE_BUSOFF) ? SW'(BUSOFF_SEQS) : SW'(NORMAL_SEQS);

    cmc_free_detect #(.RUN_LEN(RUN_LEN)) u_free (
        .clk       (clk),
        .ext_rst   (ext_rst),
        .en        (count_en),
        .bit_tick  (bit_tick),
        .bus_rx    (bus_rx),
        .seq_pulse (seq_pulse)
    );

    cmc_seq_counter #(.MAX_SEQ(MAX_SEQ)) u_seq (
        .clk       (clk),
        .ext_rst   (ext_rst),
        .en        (count_en),
        .seq_pulse (seq_pulse),
        .target    (seq_target),
        .done      (seq_done)
    );

    assign busoff_ev = bus_off & ~q.bus_off_prev;

    always_comb begin
        d              = q;
        d.bus_off_prev = bus_off;

        // register write: protected fields only while reset mode holds
        if (cpu_wr) begin
            d.rm_req = cpu_wdata[RM_BIT];
            if (q.mode.rst_mode) begin
                d.mode.filt_single = cpu_wdata[FILT_BIT];
                d.mode.self_test   = cpu_wdata[SELFT_BIT];
                d.mode.listen_only = cpu_wdata[LISTEN_BIT];
            end else begin
                d.mode.sleep = cpu_wdata[SLEEP_BIT];
            end
        end

        // software reset request lands on the half-rate phase
        if (phase_hi && (q.rm_req != q.mode.rst_mode)) begin
            d.mode.rst_mode = q.rm_req;
            if (q.rm_req) d.cause = CAUSE_CPU;
        end

        // bus-off forces reset mode at once
        if (busoff_ev) begin
            d.mode.rst_mode = 1'b1;
            d.rm_req        = 1'b1;
            d.cause         = CAUSE_BUSOFF;
        end

        if (d.mode.rst_mode) d.mode.sleep = 1'b0;

        d.abort    = d.mode.rst_mode & ~q.mode.rst_mode;
        d.err_init = busoff_ev;

        if (q.mode.rst_mode)  d.online = 1'b0;
        else if (seq_done)    d.online = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (ext_rst) q <= CTL_RST;
        else         q <= d;
    end

    assign mode_rd        = {{RSV_W{1'b0}}, q.mode};
    assign bus_on         = q.online & ~q.mode.rst_mode;
    assign xfer_abort     = q.abort;
    assign rxerr_clr      = q.err_init;
    assign txerr_load     = q.err_init;
    assign txerr_load_val = ERR_W'(TEC_INIT);
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
    input logic       clk,
    input logic       ext_rst,
    input logic [7:0] mode_rd,
    input logic       bus_off,
    input logic       bus_on,
    input logic       xfer_abort,
    input logic       rxerr_clr,
    input logic       txerr_load,
    input logic       phase_hi
);
    logic bo_seen;
    logic bo_rise;

    always_ff @(posedge clk) begin
        if (ext_rst) bo_seen <= 1'b0;
        else         bo_seen <= bus_off;
    end
    assign bo_rise = bus_off & ~bo_seen;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (ext_rst)
        mode_rd[7:5] == 3'b000);

    // R3
    cfg_locked_chk: assert property (@(posedge clk) disable iff (ext_rst)
        !mode_rd[0] |=> $stable(mode_rd[3:1]));

    // R4
    rm_on_phase_chk: assert property (@(posedge clk) disable iff (ext_rst)
        (!phase_hi && !bo_rise) |=> $stable(mode_rd[0]));

    // R5
    busoff_entry_chk: assert property (@(posedge clk) disable iff (ext_rst)
        bo_rise |=> (mode_rd[0] && rxerr_clr && txerr_load));

    // R6
    abort_on_entry_chk: assert property (@(posedge clk) disable iff (ext_rst)
        $rose(mode_rd[0]) |-> xfer_abort);

    // R6
    abort_only_in_reset_chk: assert property (@(posedge clk) disable iff (ext_rst)
        xfer_abort |-> mode_rd[0]);

    // R11
    offline_in_reset_chk: assert property (@(posedge clk) disable iff (ext_rst)
        mode_rd[0] |-> !bus_on);

    // R12
    no_sleep_in_reset_chk: assert property (@(posedge clk) disable iff (ext_rst)
        mode_rd[0] |-> !mode_rd[4]);
endmodule

bind can_mode_ctrl cmc_checker u_chk (
    .clk        (clk),
    .ext_rst    (ext_rst),
    .mode_rd    (mode_rd),
    .bus_off    (bus_off),
    .bus_on     (bus_on),
    .xfer_abort (xfer_abort),
    .rxerr_clr  (rxerr_clr),
    .txerr_load (txerr_load),
    .phase_hi   (phase_hi)
);

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       ext_rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [4:0] cpu_wdata = '0;
    logic [7:0] mode_rd;
    logic       bus_off = 1'b0;
    logic       bit_tick = 1'b0;
    logic       bus_rx = 1'b1;
    logic       bus_on;
    logic       xfer_abort;
    logic       rxerr_clr;
    logic       txerr_load;
    logic [7:0] txerr_load_val;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_mode_ctrl uut (
        .clk            (clk),
        .ext_rst        (ext_rst),
        .cpu_wr         (cpu_wr),
        .cpu_wdata      (cpu_wdata),
        .mode_rd        (mode_rd),
        .bus_off        (bus_off),
        .bit_tick       (bit_tick),
        .bus_rx         (bus_rx),
        .bus_on         (bus_on),
        .xfer_abort     (xfer_abort),
        .rxerr_clr      (rxerr_clr),
        .txerr_load     (txerr_load),
        .txerr_load_val (txerr_load_val)
    );

    typedef struct {
        string      tag;
        logic [7:0] mode;
        logic       on;
        logic       ab;
        logic       ini;
    } exp_t;

    exp_t sb[$];

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (mode_rd !== e.mode || bus_on !== e.on || xfer_abort !== e.ab ||
                rxerr_clr !== e.ini || txerr_load !== e.ini ||
                (e.ini && txerr_load_val !== 8'd127)) begin
                n_bad++;
                $display("FAIL %s: mode=%h on=%b ab=%b clr=%b ld=%b val=%0d expected mode=%h on=%b ab=%b init=%b val=127",
                         e.tag, mode_rd, bus_on, xfer_abort, rxerr_clr, txerr_load,
                         txerr_load_val, e.mode, e.on, e.ab, e.ini);
            end
        end
    end

    task automatic expect_now(input string tag, input logic [7:0] m,
                              input logic on, input logic ab, input logic ini);
        exp_t e;
        e.tag = tag; e.mode = m; e.on = on; e.ab = ab; e.ini = ini;
        sb.push_back(e);
    endtask

    task automatic step();
        @(posedge clk) #1;
    endtask

    task automatic wr(input logic [4:0] v);
        cpu_wr = 1'b1; cpu_wdata = v;
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic tick(input logic rx);
        bit_tick = 1'b1; bus_rx = rx;
        step();
        bit_tick = 1'b0; bus_rx = 1'b1;
        step();
    endtask

    task automatic free_seqs(input int n);
        for (int s = 0; s < n; s++)
            for (int b = 0; b < 11; b++) tick(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected finish before limit");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int aborts;
        repeat (3) step();
        expect_now("R1 held reset", 8'h01, 1'b0, 1'b0, 1'b0);
        ext_rst = 1'b0;
        step();
        expect_now("R1 after reset", 8'h01, 1'b0, 1'b0, 1'b0);

        // R2 R3 R12: write all ones in reset mode
        wr(5'h1F);
        expect_now("R2/R3/R12 cfg write in reset", 8'h0F, 1'b0, 1'b0, 1'b0);

        // R4: clear reset mode, old value seen first
        wr(5'h0E);
        expect_now("R4 rm not yet cleared", 8'h0F, 1'b0, 1'b0, 1'b0);
        step(); step();
        expect_now("R4 rm cleared", 8'h0E, 1'b0, 1'b0, 1'b0);

        // R3 R12: config locked, sleep writable outside reset
        wr(5'h10);
        expect_now("R3/R12 locked cfg, sleep set", 8'h1E, 1'b0, 1'b0, 1'b0);
        step(); step();
        expect_now("R3 cfg still locked", 8'h1E, 1'b0, 1'b0, 1'b0);

        // R7 R8: dominant bit restarts run, one sequence after hardware reset
        for (int b = 0; b < 10; b++) tick(1'b1);
        tick(1'b0);
        for (int b = 0; b < 10; b++) tick(1'b1);
        expect_now("R7 run restarted by dominant", 8'h1E, 1'b0, 1'b0, 1'b0);
        tick(1'b1);
        expect_now("R8 online after one sequence (hw)", 8'h1E, 1'b1, 1'b0, 1'b0);

        // R4 R6 R11: software reset
        wr(5'h01);
        expect_now("R4 sw reset pending", 8'h0E, 1'b1, 1'b0, 1'b0);
        aborts = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            if (xfer_abort) aborts++;
        end
        n_chk++;
        if (aborts != 1) begin
            n_bad++;
            $display("FAIL R6 abort pulse count: got %0d expected 1", aborts);
        end
        expect_now("R11 sw reset active", 8'h0F, 1'b0, 1'b0, 1'b0);

        // R10: ticks during reset mode do not count
        free_seqs(1);
        wr(5'h0E);
        step(); step();
        expect_now("R10 cleared again", 8'h0E, 1'b0, 1'b0, 1'b0);
        for (int b = 0; b < 10; b++) tick(1'b1);
        expect_now("R10 no credit from reset mode", 8'h0E, 1'b0, 1'b0, 1'b0);
        tick(1'b1);
        expect_now("R8 online after one sequence (cpu)", 8'h0E, 1'b1, 1'b0, 1'b0);

        // R5 R6: bus-off
        bus_off = 1'b1;
        step();
        expect_now("R5/R6 bus-off entry", 8'h0F, 1'b0, 1'b1, 1'b1);
        bus_off = 1'b0;
        step();
        expect_now("R5 pulses end", 8'h0F, 1'b0, 1'b0, 1'b0);

        // R9: 128 sequences after bus-off
        wr(5'h0E);
        step(); step();
        free_seqs(1);
        expect_now("R9 one sequence not enough", 8'h0E, 1'b0, 1'b0, 1'b0);
        free_seqs(126);
        expect_now("R9 127 sequences not enough", 8'h0E, 1'b0, 1'b0, 1'b0);
        free_seqs(1);
        expect_now("R9 online after 128 sequences", 8'h0E, 1'b1, 1'b0, 1'b0);

        // R1: write during hardware reset is ignored
        ext_rst = 1'b1; cpu_wr = 1'b1; cpu_wdata = 5'h00;
        repeat (3) step();
        ext_rst = 1'b0; cpu_wr = 1'b0;
        step();
        expect_now("R1 write ignored in reset", 8'h01, 1'b0, 1'b0, 1'b0);

        // R8: cause back to hardware, one sequence suffices
        wr(5'h00);
        step(); step();
        expect_now("R3 cfg cleared in reset", 8'h00, 1'b0, 1'b0, 1'b0);
        free_seqs(1);
        expect_now("R8 online after hw reset following bus-off", 8'h00, 1'b1, 1'b0, 1'b0);

        @(negedge clk);
        #1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule